// File: doc/BRIEF.md
# Nine-Dot Weighted Compressor Tree

This block adds up an irregular array of single-bit dots sorted by bit rank. It has two dots of weight one, four of weight two and three of weight four, and it gives their weighted total as a five-bit binary number. It is purely combinational and has no clock or reset. The typical users are filter taps and partial-product arrays, where many small terms of mixed rank must be summed in very few logic levels.

The reduction runs in strata. Each stratum is one level of small column counters, and each counter is narrow enough to fit one lookup table. The first stratum uses three counters. One of them takes dots from two neighbouring ranks: both weight-one dots and one weight-two dot. The other two are ordinary three-to-two counters, one on the remaining weight-two dots and one on the weight-four dots. This leaves at most three bits in any column.

A compile-time parameter sets how many rows the final carry-propagate adder accepts. With three rows, one stratum is enough and a ternary adder finishes the sum. With two rows, a second stratum is added before a binary adder. That stratum has a two-input counter on rank one and a three-to-two counter on rank two. Ranks zero and three pass straight through and add no counter delay.

Top module: `dot_compressor`

## Requirements
- R1: With FINAL_ROWS=3, `total` equals popcount(`col0`)·1 + popcount(`col1`)·2 + popcount(`col2`)·4 for every input combination.
- R2: With FINAL_ROWS=2, `total` equals the same weighted count for every input combination.
- R3: A single set dot gives a total of 1 in any bit of `col0`, 2 in any bit of `col1` and 4 in any bit of `col2`.
- R4: All dots clear gives `total` = 0. All nine dots set gives `total` = 22 (binary 10110).
- R5: Inside one column the bit position has no effect. Two inputs whose columns have the same number of set bits give the same `total`.
- R6: `total` never exceeds 22 for any input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| col0 | input | 2 | Dots of weight 1 |
| col1 | input | 4 | Dots of weight 2 |
| col2 | input | 3 | Dots of weight 4 |
| total | output | 5 | Weighted sum of all dots |

## Verification
The bench builds two copies side by side, one with FINAL_ROWS=3 and one with FINAL_ROWS=2. This covers both the single-stratum ternary finish and the two-stratum binary finish. All 512 input patterns are swept exhaustively on both copies, so every carry combination of the multi-rank counter and of both three-to-two counters is reached. Directed single-dot, empty, full and same-count permuted patterns isolate the rank weights. Seeded random patterns then check the upper bound of the result.

// File: rtl/dot_compressor.sv
module dot_compressor #(
  parameter int FINAL_ROWS = 3
) (
  input  logic [1:0] col0,
  input  logic [3:0] col1,
  input  logic [2:0] col2,
  output logic [4:0] total
);

  localparam int OUT_W   = 5;
  localparam int MAX_SUM = 2 * 1 + 4 * 2 + 3 * 4;

  // stratum 1: multi-rank counter (ranks 0..2), 3:2 on rank 1, 3:2 on rank 2
  logic [2:0] st1_mix;
  logic [1:0] st1_r1;
  logic [1:0] st1_r2;

  assign st1_mix = 3'(col0[0]) + 3'(col0[1]) + {1'b0, col1[0], 1'b0};
  assign st1_r1  = 2'(col1[1]) + 2'(col1[2]) + 2'(col1[3]);
  assign st1_r2  = 2'(col2[0]) + 2'(col2[1]) + 2'(col2[2]);

  function automatic int dot_value(logic [1:0] c0, logic [3:0] c1, logic [2:0] c2);
    return int'($countones(c0)) + 2 * int'($countones(c1)) + 4 * int'($countones(c2));
  endfunction

  generate
    if (FINAL_ROWS == 3) begin : g_ternary
      logic [OUT_W-1:0] row_a, row_b, row_c;
      assign row_a = {1'b0, st1_r2[1], st1_mix[2], st1_mix[1], st1_mix[0]};
      assign row_b = {2'b00, st1_r1[1], st1_r1[0], 1'b0};
      assign row_c = {2'b00, st1_r2[0], 2'b00};
      assign total = row_a + row_b + row_c;
    end else if (FINAL_ROWS == 2) begin : g_binary
      logic ha_s, ha_c, fa_s, fa_c;
      logic [OUT_W-1:0] row_a, row_b;
      assign {ha_c, ha_s} = 2'(st1_mix[1]) + 2'(st1_r1[0]);
      assign {fa_c, fa_s} = 2'(st1_mix[2]) + 2'(st1_r1[1]) + 2'(st1_r2[0]);
      assign row_a = {1'b0, fa_c, fa_s, ha_s, st1_mix[0]};
      assign row_b = {1'b0, st1_r2[1], ha_c, 2'b00};
      assign total = row_a + row_b;

      always_comb begin
        if (!$isunknown({col0, col1, col2})) begin
          // R2
          st2_value_chk: assert (int'(row_a) + int'(row_b) ==
                                 int'(st1_mix) + 2 * int'(st1_r1) + 4 * int'(st1_r2))
            else $error("second stratum changed the weighted value");
        end
      end
    end else begin : g_bad
      $error("FINAL_ROWS must be 2 or 3");
      assign total = '0;
    end
  endgenerate

  always_comb begin
    if (!$isunknown({col0, col1, col2})) begin
      // R1
      st1_value_chk: assert (int'(st1_mix) + 2 * int'(st1_r1) + 4 * int'(st1_r2) ==
                             dot_value(col0, col1, col2))
        else $error("first stratum changed the weighted value");
      // R1
      sum_match_chk: assert (int'(total) == dot_value(col0, col1, col2))
        else $error("total differs from weighted dot count");
      // R6
      no_overflow_chk: assert (int'(total) <= MAX_SUM)
        else $error("total above maximum");
      // R4
      empty_zero_chk: assert (({col0, col1, col2} != '0) || (total == '0))
        else $error("empty array gave nonzero total");
    end
  end

endmodule

// File: tb/dot_compressor_bench.sv
module dot_compressor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0] c0;
  logic [3:0] c1;
  logic [2:0] c2;
  logic [4:0] tot3, tot2;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  dot_compressor #(.FINAL_ROWS(3)) u_dot_compressor (
    .col0(c0), .col1(c1), .col2(c2), .total(tot3));
  dot_compressor #(.FINAL_ROWS(2)) u_dot_compressor_bin (
    .col0(c0), .col1(c1), .col2(c2), .total(tot2));

  function automatic int expect_sum(logic [1:0] a, logic [3:0] b, logic [2:0] c);
    int s = 0;
    for (int i = 0; i < 2; i++) s += a[i];
    for (int i = 0; i < 4; i++) s += 2 * b[i];
    for (int i = 0; i < 3; i++) s += 4 * c[i];
    return s;
  endfunction

  task automatic apply(input logic [8:0] v);
    @(negedge clk);
    {c2, c1, c0} = v;
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (c2=%b c1=%b c0=%b)", req, got, exp, c2, c1, c0);
    end
  endtask

  initial begin
    int r;
    int keep3;
    logic [8:0] v;
    // R4 empty and full
    apply(9'h000);
    check("R4", int'(tot3), 0);
    check("R4", int'(tot2), 0);
    apply(9'h1FF);
    check("R4", int'(tot3), 22);
    check("R4", int'(tot2), 22);
    // R3 single dots
    for (int b = 0; b < 9; b++) begin
      apply(9'(1) << b);
      r = (b < 2) ? 1 : (b < 6) ? 2 : 4;
      check("R3", int'(tot3), r);
      check("R3", int'(tot2), r);
    end
    // R1 and R2 exhaustive
    for (int k = 0; k < 512; k++) begin
      apply(9'(k));
      r = expect_sum(c0, c1, c2);
      check("R1", int'(tot3), r);
      check("R2", int'(tot2), r);
    end
    // R5 same counts, different positions
    apply({3'b001, 4'b0011, 2'b01});
    keep3 = int'(tot3);
    apply({3'b100, 4'b1100, 2'b10});
    check("R5", int'(tot3), keep3);
    check("R5", int'(tot2), keep3);
    apply({3'b011, 4'b0001, 2'b10});
    keep3 = int'(tot3);
    apply({3'b110, 4'b1000, 2'b01});
    check("R5", int'(tot3), keep3);
    check("R5", int'(tot2), keep3);
    // R6 seeded random
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      v = 9'($urandom);
      apply(v);
      r = expect_sum(c0, c1, c2);
      check("R6", (tot3 <= 5'd22) ? int'(tot3) : -1, r);
      check("R6", (tot2 <= 5'd22) ? int'(tot2) : -1, r);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule